// File: doc/BRIEF.md
# Duty-Cycle Slicer Threshold Controller

This block keeps the decision threshold of a data slicer centred on the demodulated eye. It sees the comparator's recovered bit stream and drives the code of an external threshold DAC. Corrections happen only while a window input marks the alternating preamble of a received burst. At all other times the code is frozen, so long runs of equal payload bits cannot pull it off centre.

Inside the window, sampled bits are counted in groups of eight. If a group has more ones than zeros, the code goes up by one LSB. If it has more zeros than ones, the code goes down by one LSB. A balanced group leaves the code unchanged. Each timeslot keeps its own converged code in a small store:

- When the window opens, the code for the selected slot is loaded into the output register.
- When the window closes, the code is written back to that slot's entry.

As a result, the same slot in the next frame starts from the value it had already reached.

Top module: `slicer_thr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, dac_code is 128 (mid-scale) and all 12 slot entries hold 128.
- R2: On the clock edge where win_en is sampled high after being low (window open), dac_code takes the stored code of the entry selected by slot_idx, visible from the next sample point.
- R3: Inside the window, each cycle with bit_tick high samples slicer_bit (1 = one). Samples form groups of 8 starting at the window open. On the edge of a group's 8th sample, dac_code rises by exactly 1 if the group held 5 or more ones.
- R4: On the 8th sample, dac_code falls by exactly 1 if the group held 3 or fewer ones, and is unchanged if it held exactly 4.
- R5: dac_code saturates at 255 and at 0 and never wraps.
- R6: While win_en is low, bit_tick and slicer_bit have no effect and dac_code is held.
- R7: On the edge where win_en is sampled low after being high (window close), the current code is written to the entry of the slot latched at the window open. A slot_idx change during the window is ignored. A partly filled group is discarded and does not carry into the next window.
- R8: Writing back one slot's entry leaves every other slot's entry unchanged.
- R9: A slot_idx of 12 or more at the window open loads 128, and closing that window writes no entry.
- R10: Cycles inside the window with bit_tick low are not counted as samples and leave dac_code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_en | input | 1 | High during the preamble acquisition window |
| bit_tick | input | 1 | One-cycle strobe marking a valid recovered bit |
| slicer_bit | input | 1 | Comparator output bit |
| slot_idx | input | 4 | Timeslot of the burst, latched at window open |
| dac_code | output | 8 | Threshold DAC code |

## Verification
The group logic is driven with several kinds of pattern:

- Balanced patterns (alternating bits, half-filled bytes) must leave the code unchanged.
- Patterns with five to seven ones or zeros must move the code by exactly one per group, which separates the "more than half" comparison from an off-by-one threshold.
- All-ones and all-zeros runs that are long enough to reach both rails expose any wrap-around.

Ticks outside the window, idle cycles inside it, and a partial group followed by a reopen show whether state leaks across windows. Reopening slots after other slots have been written shows whether the per-slot store is kept separate.

// File: rtl/slicer_thr_pkg.sv
// Shared constants and types for the slicer threshold controller.
// Assumes: 8-bit DAC code and 8-bit groups as the defaults.
package slicer_thr_pkg;
    localparam int unsigned DEF_CODE_W    = 8;
    localparam int unsigned DEF_NUM_SLOTS = 12;
    localparam int unsigned DEF_GROUP_LEN = 8;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/slicer_duty_detect.sv
// Counts sampled bits in groups of GROUP_LEN and, on the last sample of a
// group, tells whether ones or zeros were in the majority.
// Assumes: restart is a one-cycle pulse at window open; a sample on the
// same cycle counts as the group's first bit. GROUP_LEN is at least 2.
module slicer_duty_detect
    import slicer_thr_pkg::*;
#(
    parameter int unsigned GROUP_LEN = DEF_GROUP_LEN
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      sample,
    input  logic      bit_in,
    output step_dir_e step
);
    localparam int unsigned CNT_W  = $clog2(GROUP_LEN);
    localparam int unsigned ONES_W = $clog2(GROUP_LEN + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  base_cnt;
    logic [ONES_W-1:0] ones_q;
    logic [ONES_W-1:0] base_ones;
    logic [ONES_W-1:0] ones_tot;
    logic              last;

    // Majority decision on the group's final sample.
    always_comb begin
        base_cnt  = restart ? '0 : cnt_q;
        base_ones = restart ? '0 : ones_q;
        ones_tot  = base_ones + ONES_W'(bit_in);
        last      = (base_cnt == CNT_W'(GROUP_LEN - 1));
        step      = STEP_HOLD;
        if (sample && last) begin
            if ({ones_tot, 1'b0} > (ONES_W + 1)'(GROUP_LEN))
                step = STEP_UP;
            else if ({ones_tot, 1'b0} < (ONES_W + 1)'(GROUP_LEN))
                step = STEP_DOWN;
        end
    end

    // Sample and ones counters, cleared at group end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ones_q <= '0;
        end else if (sample) begin
            if (last) begin
                cnt_q  <= '0;
                ones_q <= '0;
            end else begin
                cnt_q  <= base_cnt + CNT_W'(1);
                ones_q <= ones_tot;
            end
        end else if (restart) begin
            cnt_q  <= '0;
            ones_q <= '0;
        end
    end
endmodule

// File: rtl/slicer_code_stepper.sv
// Holds the threshold code; loads a preset value or moves it by one LSB
// with saturation at both rails.
// Assumes: load and step may coincide; the step applies to the loaded value.
module slicer_code_stepper
    import slicer_thr_pkg::*;
#(
    parameter int unsigned CODE_W     = DEF_CODE_W,
    parameter int unsigned RESET_CODE = 1 << (DEF_CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    input  step_dir_e         step,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] code_nx;

    // Next code: preset first, then saturating step.
    always_comb begin
        base    = load ? load_val : code;
        code_nx = base;
        if (step == STEP_UP && base != '1)
            code_nx = base + CODE_W'(1);
        else if (step == STEP_DOWN && base != '0)
            code_nx = base - CODE_W'(1);
    end

    // Code register.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= CODE_W'(RESET_CODE);
        else        code <= code_nx;
    end
endmodule

// File: rtl/slicer_slot_store.sv
// Per-timeslot store of converged codes: asynchronous read, one write port.
// Assumes: an index at or beyond NUM_SLOTS reads INIT_CODE and never writes.
module slicer_slot_store
    import slicer_thr_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int unsigned CODE_W    = DEF_CODE_W,
    parameter int unsigned IDX_W     = $clog2(DEF_NUM_SLOTS),
    parameter int unsigned INIT_CODE = 1 << (DEF_CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_data
);
    logic [CODE_W-1:0] entry_q [NUM_SLOTS];

    // Read mux with a mid-scale default for unmapped indices.
    always_comb begin
        rd_data = CODE_W'(INIT_CODE);
        for (int i = 0; i < NUM_SLOTS; i++)
            if (rd_idx == IDX_W'(i)) rd_data = entry_q[i];
    end

    // Entry registers, reset to mid-scale, written at window close.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!rst_n)
                entry_q[i] <= CODE_W'(INIT_CODE);
            else if (we && wr_idx == IDX_W'(i))
                entry_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/slicer_thr_ctrl.sv
// Top of the duty-cycle threshold loop. Finds window open and close edges,
// latches the slot at open, preloads the code from the slot store, steps it
// from the duty detector while the window is open, and writes it back at
// close.
// Assumes: win_en covers the alternating preamble only; bit_tick is a
// one-cycle strobe per recovered bit.
module slicer_thr_ctrl
    import slicer_thr_pkg::*;
#(
    parameter int unsigned CODE_W    = DEF_CODE_W,
    parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int unsigned GROUP_LEN = DEF_GROUP_LEN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         win_en,
    input  logic                         bit_tick,
    input  logic                         slicer_bit,
    input  logic [$clog2(NUM_SLOTS)-1:0] slot_idx,
    output logic [CODE_W-1:0]            dac_code
);
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS);
    localparam int unsigned MID_CODE = 1 << (CODE_W - 1);

    logic              win_q;
    logic              open_evt;
    logic              close_evt;
    logic [SLOT_W-1:0] slot_q;
    logic [CODE_W-1:0] preload;
    step_dir_e         step;

    // Window edge detection.
    always_comb begin
        open_evt  = win_en & ~win_q;
        close_evt = ~win_en & win_q;
    end

    // Delayed window and slot latched at window open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 1'b0;
            slot_q <= '0;
        end else begin
            win_q <= win_en;
            if (open_evt) slot_q <= slot_idx;
        end
    end

    slicer_slot_store #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W),
        .IDX_W     (SLOT_W),
        .INIT_CODE (MID_CODE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (slot_idx),
        .rd_data (preload),
        .we      (close_evt),
        .wr_idx  (slot_q),
        .wr_data (dac_code)
    );

    slicer_duty_detect #(
        .GROUP_LEN (GROUP_LEN)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (open_evt),
        .sample  (win_en & bit_tick),
        .bit_in  (slicer_bit),
        .step    (step)
    );

    slicer_code_stepper #(
        .CODE_W     (CODE_W),
        .RESET_CODE (MID_CODE)
    ) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (open_evt),
        .load_val (preload),
        .step     (step),
        .code     (dac_code)
    );
endmodule

// File: rtl/slicer_thr_checker.sv
// Property checker for slicer_thr_ctrl, attached by bind.
// Assumes: an 8-bit code and a mid-scale reset value.
module slicer_thr_checker #(
    parameter int unsigned CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_en,
    input logic              bit_tick,
    input logic [CODE_W-1:0] dac_code
);
    logic win_d;

    // Own copy of the delayed window.
    always_ff @(posedge clk) begin
        if (!rst_n) win_d <= 1'b0;
        else        win_d <= win_en;
    end

    assert_reset_mid_R1: assert property (@(posedge clk)
        !rst_n |=> dac_code == CODE_W'(1 << (CODE_W - 1)));

    assert_hold_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> $stable(dac_code));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && win_d && !bit_tick) |=> $stable(dac_code));

    // Inside an open window the code moves by at most one LSB per cycle (R3, R4).
    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && win_d) |=>
            (({1'b0, dac_code}) == ({1'b0, $past(dac_code)})) ||
            (({1'b0, dac_code}) == ({1'b0, $past(dac_code)} + 1'b1)) ||
            (({1'b0, dac_code} + 1'b1) == ({1'b0, $past(dac_code)})));

    assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && win_d && dac_code == '1) |=> dac_code != '0);

    assert_no_wrap_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && win_d && dac_code == '0) |=> dac_code != '1);
endmodule

bind slicer_thr_ctrl slicer_thr_checker #(.CODE_W(CODE_W)) u_thr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_en   (win_en),
    .bit_tick (bit_tick),
    .dac_code (dac_code)
);

// File: tb/slicer_thr_ctrl_bench.sv
`timescale 1ns/1ps
module slicer_thr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic       slicer_bit = 1'b0;
    logic [3:0] slot_idx = 4'd0;
    logic [7:0] dac_code;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] exp_mem [12];

    // Each vector holds: slot[23:20], pattern[19:12] (MSB first), groups[11:8], code after close[7:0].
    localparam logic [23:0] VEC [8] = '{
        24'h0AA380, 24'h1FE383, 24'h20157B, 24'h1F8285,
        24'h2AB17C, 24'hB0F280, 24'h30047C, 24'h103481
    };

    always #4 clk = ~clk;

    slicer_thr_ctrl u_slicer_thr_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_en     (win_en),
        .bit_tick   (bit_tick),
        .slicer_bit (slicer_bit),
        .slot_idx   (slot_idx),
        .dac_code   (dac_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: dac_code=%0d expected %0d", req, act, expv);
        end
    endtask

    task automatic open_win(input logic [3:0] s);
        @(negedge clk);
        slot_idx = s;
        win_en   = 1'b1;
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic feed(input logic b);
        slicer_bit = b;
        bit_tick   = 1'b1;
        @(negedge clk);
        bit_tick   = 1'b0;
        @(negedge clk);
    endtask

    task automatic feed_group(input logic [7:0] pat);
        for (int b = 7; b >= 0; b--) feed(pat[b]);
    endtask

    task automatic close_win;
        win_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: dac_code=%0d expected end of run", dac_code);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) exp_mem[i] = 8'd128;
        repeat (3) @(negedge clk);
        check("R1 reset code", dac_code, 8'd128);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk: R2 preload, R3/R4 group steps, R1 fresh entries.
        for (int i = 0; i < 8; i++) begin
            open_win(VEC[i][23:20]);
            check("R2 preload", dac_code, exp_mem[VEC[i][23:20]]);
            for (int g = 0; g < int'(VEC[i][11:8]); g++) feed_group(VEC[i][19:12]);
            close_win();
            check("R3/R4 group steps", dac_code, VEC[i][7:0]);
            exp_mem[VEC[i][23:20]] = VEC[i][7:0];
        end

        // R5 upper rail.
        open_win(4'd4);
        for (int g = 0; g < 130; g++) feed_group(8'hFF);
        check("R5 saturate high", dac_code, 8'd255);
        close_win();

        // R6 ticks outside the window.
        for (int k = 0; k < 40; k++) feed(1'b1);
        check("R6 hold outside ones", dac_code, 8'd255);
        for (int k = 0; k < 40; k++) feed(1'b0);
        check("R6 hold outside zeros", dac_code, 8'd255);
        open_win(4'd4);
        check("R2 reload slot 4", dac_code, 8'd255);
        feed_group(8'hFF);
        check("R5 stays at 255", dac_code, 8'd255);
        close_win();

        // R5 lower rail.
        open_win(4'd5);
        for (int g = 0; g < 131; g++) feed_group(8'h00);
        check("R5 saturate low", dac_code, 8'd0);
        close_win();

        // R10 idle cycles inside the window.
        open_win(4'd8);
        repeat (20) @(negedge clk);
        check("R10 no tick no change", dac_code, 8'd128);
        feed_group(8'hF0);
        check("R4 balanced holds", dac_code, 8'd128);
        feed_group(8'hFF);
        check("R3 step up", dac_code, 8'd129);
        close_win();

        // R7 slot change mid-window and discarded partial group.
        open_win(4'd6);
        feed_group(8'hFF);
        slot_idx = 4'd7;
        for (int k = 0; k < 5; k++) feed(1'b1);
        check("R3 partial group no step", dac_code, 8'd129);
        close_win();
        open_win(4'd7);
        check("R7 slot change ignored", dac_code, 8'd128);
        close_win();
        open_win(4'd6);
        check("R7 written to latched slot", dac_code, 8'd129);
        for (int k = 0; k < 3; k++) feed(1'b1);
        check("R7 partial discarded", dac_code, 8'd129);
        close_win();

        // R9 out-of-range slot.
        open_win(4'd13);
        check("R9 out-of-range preload", dac_code, 8'd128);
        feed_group(8'hFF);
        feed_group(8'hFF);
        check("R9 steps still run", dac_code, 8'd130);
        close_win();
        open_win(4'd13);
        check("R9 no write-back", dac_code, 8'd128);
        close_win();

        // R8 independent entries.
        open_win(4'd1);
        check("R8 slot 1 intact", dac_code, exp_mem[1]);
        close_win();
        open_win(4'd2);
        check("R8 slot 2 intact", dac_code, exp_mem[2]);
        close_win();
        open_win(4'd5);
        check("R8 slot 5 intact", dac_code, 8'd0);
        close_win();
        open_win(4'd9);
        check("R1 untouched slot mid", dac_code, 8'd128);
        close_win();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule